// File: doc/BRIEF.md
# AMI Burst Frame Encoder

This block sends one burst frame on a two-wire line drive. The line code is half-bauded alternate mark inversion. A zero bit produces no pulse. A one bit produces a pulse in the first half of its bit period, and the line returns to neutral for the second half. Successive ordinary pulses alternate in polarity. The clock runs at twice the bit rate, so every bit takes two ticks.

A frame is requested with a one-tick start strobe while the block is idle. All channel inputs are captured on that edge. The block then sends the fields in this order:

- a framing bit, always a mark;
- bearer channel 1, MSB first;
- bearer channel 2, MSB first;
- the D channel, MSB first;
- one M bit.

The M bit follows a four-frame superframe. Frame phase 0 carries a deliberate code violation, which is a mark of the same polarity as the previous pulse. Phases 1 and 3 carry the transparent bit, and phase 2 carries the service bit. A frame that carried a violation is extended by one balancing mark, whose polarity is opposite to the violating pulse. The next ordinary pulse after the balancing mark takes the polarity opposite to the balancing mark.

The sequencer states are:

| State | Role | Next state |
|-------|------|------------|
| ST_IDLE | Waiting | ST_LF on an accepted start |
| ST_LF | Framing bit | ST_B1 |
| ST_B1 | Bearer channel 1 | ST_B2 |
| ST_B2 | Bearer channel 2 | ST_D |
| ST_D | D channel | ST_M |
| ST_M | M bit | ST_DC when the phase is the violation slot, otherwise ST_IDLE |
| ST_DC | Balancing mark | ST_IDLE |

Each field state covers two ticks per bit of its field.

Top module: `ami_burst_encoder`

## Requirements
- R1: After reset, `line_pos`, `line_neg` and `busy` are low. The first mark after reset is positive, and the first frame uses superframe phase 0.
- R2: A zero bit drives both line outputs low in both of its ticks.
- R3: A mark pulses in the first tick of its bit only. Both outputs are low in the second tick.
- R4: Ordinary marks alternate in polarity. This holds within a frame and across frames.
- R5: Field order is framing bit (always 1), `b1_data` then `b2_data` then `d_data`, each MSB first, then M. The frame is 22 bits, or 44 ticks.
- R6: The M bit follows the superframe phase. The phase is the frame count since reset, modulo 4. Phase 0 is the violation slot, phases 1 and 3 send `t_bit`, and phase 2 sends `s_bit`.
- R7: In phase 0 the M bit is a mark with the same polarity as the previous pulse. `t_bit` and `s_bit` have no effect on it.
- R8: A phase-0 frame has a 23rd bit. That bit is a mark opposite to the violation. The next ordinary mark is opposite to that balancing mark.
- R9: `busy` rises in the tick after an accepted start. It stays high through the last tick of the frame and is low in the tick after that.
- R10: A start while `busy` is high is ignored. This includes a start in the final tick. Data inputs are sampled only on an accepted start.
- R11: `line_pos` and `line_neg` are never high in the same tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-bit tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst start strobe |
| b1_data | input | 8 | Bearer channel 1 |
| b2_data | input | 8 | Bearer channel 2 |
| d_data | input | 4 | D channel |
| t_bit | input | 1 | Transparent bit for M phases 1 and 3 |
| s_bit | input | 1 | Service bit for M phase 2 |
| line_pos | output | 1 | Positive pulse drive |
| line_neg | output | 1 | Negative pulse drive |
| busy | output | 1 | Frame in progress |

## Verification
Two events can fall in the same tick: a new start strobe and the final tick of a frame. That final tick is often the balancing mark that follows a violation. The bench raises start in the last tick of selected frames and at random ticks inside others. It also scrambles the data inputs right after each accepted start. It then judges that `busy` still falls one tick later and that no extra pulse appears. The line pattern of later frames must stay equal to the model, which keeps its own polarity and superframe phase.

// File: rtl/ami_enc_pkg.sv
package ami_enc_pkg;

    localparam int SF_FRAMES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LF,
        ST_B1,
        ST_B2,
        ST_D,
        ST_M,
        ST_DC
    } frm_state_e;

    typedef enum logic [1:0] {
        MK_NONE,
        MK_NORM,
        MK_VIOL,
        MK_BAL
    } mark_kind_e;

    typedef enum logic [1:0] {
        MS_CV,
        MS_T,
        MS_S
    } mslot_e;

endpackage

// File: rtl/ami_sf_phase.sv
module ami_sf_phase
    import ami_enc_pkg::*;
#(
    parameter int FRAMES = SF_FRAMES
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_done,
    output mslot_e slot
);
    localparam int PH_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAMES - 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (frame_done) begin
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
        end
    end

    always_comb begin
        if (phase_q == '0) begin
            slot = MS_CV;
        end else if (phase_q[0]) begin
            slot = MS_T;
        end else begin
            slot = MS_S;
        end
    end

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && phase_q != PH_LAST) |=> (phase_q == $past(phase_q) + 1'b1)); // R6

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && phase_q == PH_LAST) |=> (slot == MS_CV)); // R6

endmodule

// File: rtl/ami_frame_seq.sv
module ami_frame_seq
    import ami_enc_pkg::*;
#(
    parameter int CH_W = 8,
    parameter int D_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CH_W-1:0] b1_data,
    input  logic [CH_W-1:0] b2_data,
    input  logic [D_W-1:0]  d_data,
    input  logic            t_bit,
    input  logic            s_bit,
    input  mslot_e          slot,
    output logic            busy,
    output logic            fire,
    output mark_kind_e      kind,
    output logic            frame_done
);
    localparam int PAY_W   = 2 * CH_W + D_W;
    localparam int FLD_MAX = (CH_W > D_W) ? CH_W : D_W;
    localparam int IDX_W   = $clog2(FLD_MAX + 1);

    frm_state_e       state_q, state_d, nxt_fld;
    logic             half_q, half_d;
    logic [IDX_W-1:0] idx_q, idx_d, fld_len;
    logic [PAY_W-1:0] pay_q;
    logic             t_q, s_q;
    logic             load, shift, fld_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= 1'b0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
            idx_q   <= idx_d;
        end
    end

    // captured frame content
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pay_q <= '0;
            t_q   <= 1'b0;
            s_q   <= 1'b0;
        end else if (load) begin
            pay_q <= {b1_data, b2_data, d_data};
            t_q   <= t_bit;
            s_q   <= s_bit;
        end else if (shift) begin
            pay_q <= {pay_q[PAY_W-2:0], 1'b0};
        end
    end

    // field length and successor
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin fld_len = IDX_W'(1);    nxt_fld = ST_IDLE; end
            ST_LF:   begin fld_len = IDX_W'(1);    nxt_fld = ST_B1;   end
            ST_B1:   begin fld_len = IDX_W'(CH_W); nxt_fld = ST_B2;   end
            ST_B2:   begin fld_len = IDX_W'(CH_W); nxt_fld = ST_D;    end
            ST_D:    begin fld_len = IDX_W'(D_W);  nxt_fld = ST_M;    end
            ST_M:    begin
                fld_len = IDX_W'(1);
                nxt_fld = (slot == MS_CV) ? ST_DC : ST_IDLE;
            end
            ST_DC:   begin fld_len = IDX_W'(1);    nxt_fld = ST_IDLE; end
            default: begin fld_len = IDX_W'(1);    nxt_fld = ST_IDLE; end
        endcase
    end

    assign fld_last = (idx_q == fld_len - 1'b1);

    // next-state logic
    always_comb begin
        state_d    = state_q;
        half_d     = half_q;
        idx_d      = idx_q;
        load       = 1'b0;
        shift      = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_LF;
                    half_d  = 1'b0;
                    idx_d   = '0;
                    load    = 1'b1;
                end
            end
            ST_LF, ST_B1, ST_B2, ST_D, ST_M, ST_DC: begin
                if (!half_q) begin
                    half_d = 1'b1;
                end else begin
                    half_d = 1'b0;
                    shift  = (state_q == ST_B1) || (state_q == ST_B2) ||
                             (state_q == ST_D);
                    if (fld_last) begin
                        idx_d      = '0;
                        state_d    = nxt_fld;
                        frame_done = (nxt_fld == ST_IDLE);
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        fire = busy && !half_q;
        kind = MK_NONE;
        unique case (state_q)
            ST_IDLE: kind = MK_NONE;
            ST_LF:   kind = MK_NORM;
            ST_B1, ST_B2, ST_D:
                     kind = pay_q[PAY_W-1] ? MK_NORM : MK_NONE;
            ST_M: begin
                unique case (slot)
                    MS_CV:   kind = MK_VIOL;
                    MS_T:    kind = t_q ? MK_NORM : MK_NONE;
                    MS_S:    kind = s_q ? MK_NORM : MK_NONE;
                    default: kind = MK_NONE;
                endcase
            end
            ST_DC:   kind = MK_BAL;
            default: kind = MK_NONE;
        endcase
    end

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && state_q == ST_LF)); // R9

    AST_DC_AFTER_M: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DC && half_q == 1'b0) |-> ($past(state_q) == ST_M)); // R8

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_done && state_q != ST_M) |=> busy); // R10

endmodule

// File: rtl/ami_pol_track.sv
module ami_pol_track
    import ami_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  mark_kind_e kind,
    output logic       line_pos,
    output logic       line_neg
);
    logic nxt_pos_q;
    logic last_pos_q;
    logic emit, pol;

    always_comb begin
        emit = fire && (kind != MK_NONE);
        unique case (kind)
            MK_NONE: pol = nxt_pos_q;
            MK_NORM: pol = nxt_pos_q;
            MK_VIOL: pol = !nxt_pos_q;
            MK_BAL:  pol = nxt_pos_q;
            default: pol = nxt_pos_q;
        endcase
        line_pos = emit && pol;
        line_neg = emit && !pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_pos_q <= 1'b1;
        end else if (emit && kind != MK_VIOL) begin
            nxt_pos_q <= !nxt_pos_q;
        end
    end

    // polarity of the last pulse put on the line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_pos_q <= 1'b0;
        end else if (emit) begin
            last_pos_q <= line_pos;
        end
    end

    AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pos && line_neg)); // R11

    AST_HALF_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pos || line_neg) |=> !(line_pos || line_neg)); // R3

    AST_CV_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && kind == MK_VIOL) |-> (line_pos == last_pos_q)); // R7

    AST_DC_OPPOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && kind == MK_BAL) |-> (line_pos != last_pos_q)); // R8

endmodule

// File: rtl/ami_burst_encoder.sv
module ami_burst_encoder
    import ami_enc_pkg::*;
#(
    parameter int CH_W = 8,
    parameter int D_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CH_W-1:0] b1_data,
    input  logic [CH_W-1:0] b2_data,
    input  logic [D_W-1:0]  d_data,
    input  logic            t_bit,
    input  logic            s_bit,
    output logic            line_pos,
    output logic            line_neg,
    output logic            busy
);
    mslot_e     slot;
    mark_kind_e kind;
    logic       fire;
    logic       frame_done;

    ami_sf_phase #(
        .FRAMES(SF_FRAMES)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .slot       (slot)
    );

    ami_frame_seq #(
        .CH_W(CH_W),
        .D_W (D_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .b1_data    (b1_data),
        .b2_data    (b2_data),
        .d_data     (d_data),
        .t_bit      (t_bit),
        .s_bit      (s_bit),
        .slot       (slot),
        .busy       (busy),
        .fire       (fire),
        .kind       (kind),
        .frame_done (frame_done)
    );

    ami_pol_track u_pol (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .kind     (kind),
        .line_pos (line_pos),
        .line_neg (line_neg)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(line_pos || line_neg)); // R9

endmodule

// File: tb/ami_burst_encoder_tb.sv
module ami_burst_encoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] b1_data = '0;
    logic [7:0] b2_data = '0;
    logic [3:0] d_data = '0;
    logic       t_bit = 1'b0;
    logic       s_bit = 1'b0;
    logic       line_pos, line_neg, busy;

    int n_chk = 0;
    int n_bad = 0;
    int frames = 0;
    int cycles = 0;
    bit m_nxt = 1'b1;
    bit m_last = 1'b0;
    int m_phase = 0;

    always #10 clk = ~clk;

    ami_burst_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .b1_data(b1_data), .b2_data(b2_data), .d_data(d_data),
        .t_bit(t_bit), .s_bit(s_bit),
        .line_pos(line_pos), .line_neg(line_neg), .busy(busy)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s frame %0d: act=%b exp=%b", req, what, frames, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "idle pos", line_pos, 1'b0);
        chk(req, "idle neg", line_neg, 1'b0);
        chk(req, "idle busy", busy, 1'b0);
    endtask

    // kind codes: 0 zero, 1 ordinary mark, 2 violation, 3 balancing mark
    task automatic run_frame(input logic [7:0] a, input logic [7:0] bb, input logic [3:0] dd,
                             input logic t, input logic s, input int poke);
        int kinds[23];
        int nb;
        string req;
        bit ep;
        bit en;
        kinds[0] = 1;
        for (int i = 0; i < 8; i++) kinds[1+i] = a[7-i] ? 1 : 0;
        for (int i = 0; i < 8; i++) kinds[9+i] = bb[7-i] ? 1 : 0;
        for (int i = 0; i < 4; i++) kinds[17+i] = dd[3-i] ? 1 : 0;
        if (m_phase == 0) kinds[21] = 2;
        else if (m_phase == 2) kinds[21] = s ? 1 : 0;
        else kinds[21] = t ? 1 : 0;
        kinds[22] = 3;
        nb = (m_phase == 0) ? 23 : 22;

        @(negedge clk);
        b1_data = a; b2_data = bb; d_data = dd; t_bit = t; s_bit = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: inputs after the accepted start must not matter
        b1_data = ~a; b2_data = ~bb; d_data = ~dd; t_bit = ~t; s_bit = ~s;
        for (int k = 0; k < nb; k++) begin
            for (int h = 0; h < 2; h++) begin
                ep = 1'b0; en = 1'b0;
                if (h == 1) req = "R3";
                else if (kinds[k] == 0) req = "R2";
                else if (k == 0 && frames == 0) req = "R1";
                else if (k == 0) req = "R5";
                else if (k == 21 && kinds[k] == 1) req = "R6";
                else if (kinds[k] == 2) req = "R7";
                else if (kinds[k] == 3) req = "R8";
                else req = "R4";
                if (h == 0 && kinds[k] != 0) begin
                    unique case (kinds[k])
                        1: begin ep = m_nxt; m_last = ep; m_nxt = !m_nxt; end
                        2: begin ep = m_last; end
                        default: begin ep = !m_last; m_last = ep; m_nxt = !ep; end
                    endcase
                    en = !ep;
                end
                chk(req, $sformatf("pos bit %0d tick %0d", k, h), line_pos, ep);
                chk(req, $sformatf("neg bit %0d tick %0d", k, h), line_neg, en);
                chk((poke >= 0) ? "R10" : "R9", $sformatf("busy bit %0d", k), busy, 1'b1);
                chk("R11", "both drives", line_pos & line_neg, 1'b0);
                start = (2 * k + h == poke);
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk_idle((poke >= 0) ? "R10" : "R9");
        m_phase = (m_phase + 1) % 4;
        frames++;
    endtask

    initial begin
        void'($urandom(32'd20571));
        #5;
        chk_idle("R1");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        // directed: all zeros over a full superframe, then all ones
        for (int f = 0; f < 4; f++) run_frame(8'h00, 8'h00, 4'h0, 1'b0, 1'b0, -1);
        for (int f = 0; f < 4; f++) run_frame(8'hFF, 8'hFF, 4'hF, 1'b1, 1'b1, -1);
        // start in the final tick of a violation frame (46 ticks) and a plain one (44 ticks)
        run_frame(8'hA5, 8'h3C, 4'h9, 1'b1, 1'b0, 45);
        run_frame(8'h81, 8'h7E, 4'h6, 1'b0, 1'b1, 43);
        // back-to-back start right as busy falls
        run_frame(8'h01, 8'h80, 4'h1, 1'b1, 1'b1, -1);

        for (int f = 0; f < 40; f++) begin
            int poke;
            poke = ($urandom % 3 == 0) ? int'($urandom % 46) : -1;
            run_frame(8'($urandom), 8'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), poke);
            repeat ($urandom % 3) begin
                @(negedge clk);
                chk_idle("R9");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule